// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the bus-facing controller of a 128-byte serial memory reached over a two-wire bus. The clock line and the open-drain data line are sampled with the system clock. The block finds START and STOP conditions on those lines and takes in a first byte. That byte carries a 7-bit word address and then a direction bit. There is no separate device-select byte.

On a write, every received data byte is acknowledged and handed to an external write buffer as a one-cycle strobe, together with its address. A STOP that closes a write with at least one data byte raises a commit pulse. On a read, bytes come from an internal 128-by-8 array. They go out MSB first, and the address advances after each byte the master acknowledges.

While the external buffer reports a programming cycle in progress, the block does not acknowledge the address byte and keeps off the bus. A host can therefore poll until the write has finished. The write buffer loads the array through a separate programming port.

Top module: `tw_mem_slave`

## Requirements
- R1: After reset the data-line pull (`sda_oe_o`), the write strobe and the commit pulse are all low.
- R2: Until a START is seen (SDA falling while SCL is high), clock pulses and data changes cause no SDA pull and no write strobe.
- R3: The first byte after START is read MSB first as bits [7:1] = word address and bit [0] = direction (0 write, 1 read). When `busy_i` is low, the block pulls SDA low during the ninth SCL high phase.
- R4: In a write, each complete data byte is acknowledged on its ninth clock and presented once on `wr_valid_o` with `wr_addr_o`/`wr_data_o`. Successive bytes take successive addresses, and the address wraps from 127 to 0.
- R5: A STOP that ends a write in which at least one data byte was taken gives exactly one `wr_commit_o` pulse. Any other STOP gives none.
- R6: A read sends the byte at the word address MSB first. Each master ACK (SDA low on the ninth clock) is followed by the byte at the next address, and the address wraps from 127 to 0.
- R7: After a master NACK (SDA high on the ninth clock), the block leaves SDA released until the next START or STOP.
- R8: While `busy_i` is high at the acknowledge slot, the address byte is not acknowledged. SDA stays released and no bytes are taken until the next START or STOP.
- R9: The SDA pull changes only in the cycle after a detected SCL falling edge, or on START or STOP. It never changes while SCL is high.
- R10: A repeated START in any state restarts address reception. A partly received byte is dropped without a write strobe.
- R11: A STOP in any state returns the block to idle and drops a partly received byte without a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls the data line low |
| wr_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 7 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse on STOP ending a write with data |
| busy_i | input | 1 | Programming cycle in progress |
| prog_we_i | input | 1 | Array write enable from the write buffer |
| prog_addr_i | input | 7 | Array write address |
| prog_data_i | input | 8 | Array write data |

## Verification
The embedded assertions check the following on every cycle:
- the SDA pull changes only after a detected SCL fall or a START or STOP;
- the line stays released in the idle and silent states;
- a busy acknowledge slot never pulls the line;
- write strobes are single cycles and never follow a STOP;
- commits come only from a STOP.

The bench scenarios are needed for the rest:
- the data values and address wrap in sequential reads and writes;
- ignoring a bus with no START;
- silence after a master NACK;
- polling during a busy cycle;
- aborts by a repeated START or a STOP in the middle of a byte.

// File: rtl/tw_mem_slave.sv
module tw_mem_slave #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_commit_o,
  input  logic          busy_i,
  input  logic          prog_we_i,
  input  logic [AW-1:0] prog_addr_i,
  input  logic [DW-1:0] prog_data_i
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);
  localparam logic [CW-1:0] FULL = CW'(DW);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_WAIT
  } st_t;

  logic [DW-1:0] mem [DEPTH];
  logic [2:0] scl_sy, sda_sy;
  st_t st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic [AW-1:0] ptr;
  logic rw_q, ninth, acked, wr_any;

  always_ff @(posedge clk) begin
    if (prog_we_i) mem[prog_addr_i] <= prog_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_i};
      sda_sy <= {sda_sy[1:0], sda_i};
    end
  end

  wire scl_now = scl_sy[1];
  wire scl_prv = scl_sy[2];
  wire sda_now = sda_sy[1];
  wire sda_prv = sda_sy[2];
  wire scl_rise = scl_now & ~scl_prv;
  wire scl_fall = ~scl_now & scl_prv;
  wire start_det = scl_now & scl_prv & sda_prv & ~sda_now;
  wire stop_det = scl_now & scl_prv & ~sda_prv & sda_now;

  wire [DW-1:0] rx_byte = {sh[DW-2:0], sda_now};
  wire [AW-1:0] ptr_nx = ptr + 1'b1;
  wire [DW-1:0] rd_cur = mem[ptr];
  wire [DW-1:0] rd_nxt = mem[ptr_nx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      ptr <= '0;
      rw_q <= 1'b0;
      ninth <= 1'b0;
      acked <= 1'b0;
      wr_any <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_commit_o <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      wr_commit_o <= 1'b0;
      if (stop_det) begin
        st <= S_IDLE;
        sda_oe_o <= 1'b0;
        wr_commit_o <= wr_any;
        wr_any <= 1'b0;
      end else if (start_det) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st)
          S_ADDR: if (scl_rise) begin
            sh <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              ptr <= rx_byte[AW:1];
              rw_q <= rx_byte[0];
              ninth <= 1'b0;
              cnt <= '0;
              st <= S_AACK;
            end
          end
          S_AACK: begin
            if (scl_rise) ninth <= 1'b1;
            if (scl_fall && !ninth) begin
              sda_oe_o <= ~busy_i;
              acked <= ~busy_i;
            end else if (scl_fall) begin
              cnt <= '0;
              if (!acked) begin
                sda_oe_o <= 1'b0;
                st <= S_WAIT;
              end else if (!rw_q) begin
                sda_oe_o <= 1'b0;
                st <= S_WDAT;
              end else begin
                sda_oe_o <= ~rd_cur[DW-1];
                sh <= rd_cur << 1;
                st <= S_RDAT;
              end
            end
          end
          S_WDAT: if (scl_rise) begin
            sh <= rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              wr_valid_o <= 1'b1;
              wr_addr_o <= ptr;
              wr_data_o <= rx_byte;
              wr_any <= 1'b1;
              ptr <= ptr_nx;
              ninth <= 1'b0;
              cnt <= '0;
              st <= S_WACK;
            end
          end
          S_WACK: begin
            if (scl_rise) ninth <= 1'b1;
            if (scl_fall && !ninth) begin
              sda_oe_o <= 1'b1;
            end else if (scl_fall) begin
              sda_oe_o <= 1'b0;
              st <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe_o <= 1'b0;
                ninth <= 1'b0;
                st <= S_RACK;
              end else begin
                sda_oe_o <= ~sh[DW-1];
                sh <= sh << 1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              ninth <= 1'b1;
              acked <= ~sda_now;
            end
            if (scl_fall && ninth) begin
              cnt <= '0;
              if (acked) begin
                ptr <= ptr_nx;
                sda_oe_o <= ~rd_nxt[DW-1];
                sh <= rd_nxt << 1;
                st <= S_RDAT;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_oe_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_fall) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_o));
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe_o);
  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> !sda_oe_o);
  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_AACK && !ninth && scl_fall && busy_i && !start_det && !stop_det) |=> !sda_oe_o);
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);
  p_commit_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit_o |-> $past(stop_det));
  p_stop_nowr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !wr_valid_o);
endmodule

// File: tb/tw_mem_slave_tb_top.sv
module tw_mem_slave_tb_top;
  localparam int Q = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0;
  logic prog_we = 1'b0;
  logic [6:0] prog_addr = '0;
  logic [7:0] prog_data = '0;
  logic sda_oe, wr_valid, wr_commit;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  wire sda_line = m_sda & ~sda_oe;

  tw_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .wr_commit_o(wr_commit), .busy_i(busy),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int cap_n = 0, commit_n = 0, oe_cnt = 0, r9_bad = 0;
  logic [6:0] cap_a [64];
  logic [7:0] cap_d [64];
  logic [7:0] model [128];
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  bit done = 0;

  always @(posedge clk) begin
    if (wr_valid && cap_n < 64) begin
      cap_a[cap_n] = wr_addr;
      cap_d[cap_n] = wr_data;
      cap_n++;
    end
    if (wr_commit) commit_n++;
    if (sda_oe) oe_cnt++;
    if (m_scl && prev_scl && sda_oe != prev_oe) r9_bad++;
    prev_oe = sda_oe;
    prev_scl = m_scl;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic m_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic m_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_line; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic prog(input logic [6:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    @(posedge clk); #2;
    prog_we = 1'b0;
    model[a] = d;
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
    check(wr_valid == 1'b0, "R1 wr_valid", wr_valid, 0);
    check(wr_commit == 1'b0, "R1 commit", wr_commit, 0);
  endtask

  task automatic t_noise();
    int oe0 = oe_cnt, c0 = cap_n;
    for (int i = 0; i < 12; i++) begin
      m_scl = 1'b0; wq();
      m_sda = i[0]; wq();
      m_scl = 1'b1; wq(); wq();
    end
    m_scl = 1'b0; wq(); m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    check(oe_cnt == oe0, "R2 no pull before START", oe_cnt - oe0, 0);
    check(cap_n == c0, "R2 no strobe before START", cap_n - c0, 0);
  endtask

  task automatic t_byte_read(input logic [6:0] a);
    logic ack;
    logic [7:0] v;
    m_start();
    send_byte({a, 1'b1}, ack);
    check(ack, "R3 address ack", ack, 1);
    recv_byte(1'b0, v);
    check(v == model[a], "R6 byte read", v, model[a]);
    m_stop();
  endtask

  task automatic t_seq_read_wrap();
    logic ack;
    logic [7:0] v;
    m_start();
    send_byte({7'd126, 1'b1}, ack);
    check(ack, "R3 address ack seq", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i != 3, v);
      check(v == model[7'(126 + i)], "R6 sequential read wrap", v, model[7'(126 + i)]);
    end
    m_stop();
  endtask

  task automatic t_nack_silent();
    logic ack, b;
    logic [7:0] v;
    int ones = 0;
    m_start();
    send_byte({7'd10, 1'b1}, ack);
    recv_byte(1'b0, v);
    for (int i = 0; i < 9; i++) begin
      recv_bit(b);
      if (b) ones++;
    end
    check(ones == 9, "R7 silent after NACK", ones, 9);
    m_stop();
  endtask

  task automatic t_write();
    logic ack;
    int c0 = cap_n, k0 = commit_n, acks = 0;
    m_start();
    send_byte({7'h7E, 1'b0}, ack);
    check(ack, "R3 write address ack", ack, 1);
    for (int i = 0; i < 3; i++) begin
      send_byte(8'hA0 + 8'(i), ack);
      if (ack) acks++;
    end
    check(acks == 3, "R4 data bytes acked", acks, 3);
    m_stop();
    wq();
    check(cap_n - c0 == 3, "R4 strobe count", cap_n - c0, 3);
    for (int i = 0; i < 3; i++) begin
      check(cap_a[c0 + i] == 7'(126 + i), "R4 address wrap", cap_a[c0 + i], 7'(126 + i));
      check(cap_d[c0 + i] == 8'hA0 + 8'(i), "R4 data", cap_d[c0 + i], 8'hA0 + 8'(i));
    end
    check(commit_n - k0 == 1, "R5 one commit", commit_n - k0, 1);
  endtask

  task automatic t_busy();
    logic ack;
    logic [7:0] v;
    int c0 = cap_n, k0 = commit_n, oe0;
    busy = 1'b1;
    m_start();
    oe0 = oe_cnt;
    send_byte({7'h05, 1'b0}, ack);
    check(!ack, "R8 no ack while busy", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R8 data ignored while busy", ack, 0);
    check(oe_cnt == oe0, "R8 line released while busy", oe_cnt - oe0, 0);
    m_stop();
    wq();
    check(cap_n == c0, "R8 no strobe while busy", cap_n - c0, 0);
    check(commit_n == k0, "R5 no commit without data", commit_n - k0, 0);
    for (int i = 0; i < 3; i++) prog(cap_a[c0 - 3 + i], cap_d[c0 - 3 + i]);
    busy = 1'b0;
    m_start();
    send_byte({7'h7E, 1'b1}, ack);
    check(ack, "R3 ack after busy ends", ack, 1);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, v);
      check(v == 8'hA0 + 8'(i), "R4 written data read back", v, 8'hA0 + 8'(i));
    end
    m_stop();
  endtask

  task automatic t_rep_start();
    logic ack;
    logic [7:0] v;
    int c0 = cap_n;
    m_start();
    send_byte({7'h20, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    m_start();
    send_byte({7'h33, 1'b1}, ack);
    check(ack, "R10 address after repeated START", ack, 1);
    recv_byte(1'b0, v);
    check(v == model[7'h33], "R10 read after repeated START", v, model[7'h33]);
    m_stop();
    wq();
    check(cap_n == c0, "R10 partial byte dropped", cap_n - c0, 0);
  endtask

  task automatic t_stop_abort();
    logic ack;
    int c0 = cap_n, k0 = commit_n;
    m_start();
    send_byte({7'h40, 1'b0}, ack);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    m_stop();
    wq();
    check(cap_n == c0, "R11 partial byte dropped on STOP", cap_n - c0, 0);
    check(commit_n == k0, "R11 no commit on aborted write", commit_n - k0, 0);
    t_byte_read(7'h41);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    wq();
    for (int a = 0; a < 128; a++) prog(7'(a), 8'((a * 37 + 5) & 8'hFF));
    t_noise();
    t_byte_read(7'h11);
    t_seq_read_wrap();
    t_nack_silent();
    t_write();
    t_busy();
    t_rep_start();
    t_stop_abort();
    check(r9_bad == 0, "R9 no pull change while SCL high", r9_bad, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule